// File: doc/BRIEF.md
# Byte-Addressed SRAM Controller with Posted Write

This block sits between a processor-side request port and a synchronous single-ported word array. It accepts byte, halfword and word reads and writes at byte addresses. Writes are posted into a one-entry holding register, so a write is accepted in the cycle it is presented and never stalls the requester. The held write reaches the array only when the next write request arrives. In that same cycle the old entry is committed with its own byte-lane mask and the new entry is captured.

Reads take one cycle and return the whole naturally aligned word. If the held write targets that word, its enabled bytes are laid over the array data, so software always sees its latest write. A reset empties the holding register without committing it. The array then keeps only the writes that a later write pushed out. Writing the same value twice in a row, or following a write with any other write, makes sure the data survives a reset.

Top module: `sram_wbuf_ctrl`

## Requirements
- R1: `req_size` encodes 2'b00 = byte, 2'b01 = halfword, 2'b10 or 2'b11 = word. A word access ignores address bits 1:0, and a halfword access ignores address bit 0. Write data is right-justified in `req_wdata`: a byte in bits 7:0, a halfword in bits 15:0.
- R2: Lane i of a word is bits 8i+7:8i and holds byte address 4*word+i (little-endian). A write changes only the lanes it covers, and the other bytes of the word keep their stored values.
- R3: A write is accepted in the cycle it is presented. The array is not updated at that time. It is updated only when a later write request is accepted.
- R4: A read of the word addressed by the held write returns the held bytes in their enabled lanes and the array bytes in the remaining lanes.
- R5: A read accepted at clock edge t raises `rsp_valid` for exactly the cycle after t, with the full aligned 32-bit word on `rsp_rdata`. `rsp_valid` is low in every other cycle.
- R6: Reset discards a held write. After reset, that location reads back its previously committed contents.
- R7: Two identical consecutive writes to one location leave the data in the array, and the data is still readable after a reset.
- R8: While `rst_n` is low, `req_ready` and `rsp_valid` are low. `req_ready` is high from the first clock edge after reset is released.
- R9: Back-to-back writes to different words need no idle cycle. Each write is committed to its own word with its own lane mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size (R1 encoding) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Right-justified write data |
| req_ready | output | 1 | Requests are accepted (high after reset) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Aligned read word, merged with the held write |

## Verification
The assertions assume that a request is presented only while `req_ready` is high and that `req_size` and `req_addr` are stable within the cycle of the request. They also assume that reads and writes never arrive together, because the interface carries a single request per cycle. The bench drives one request per negative clock edge, using only the defined size codes and only addresses within the configured array. Before it checks any read data it fills every word and forces a commit, so no read returns uninitialised array contents.

// File: rtl/sram_wbuf_pkg.sv
// Shared encodings for the posted-write SRAM controller.
// Assumes a 32-bit data path split into four byte lanes.
package sram_wbuf_pkg;
    localparam int LANES  = 4;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WRD2 = 2'b11
    } acc_size_e;
endpackage

// File: rtl/sram_wbuf_lanes.sv
// Turns a byte address, an access size and right-justified data into a word
// address, a byte-lane mask and lane-positioned data.
// Assumes little-endian lane order. Size codes 2'b10 and 2'b11 both mean word.
module sram_wbuf_lanes
    import sram_wbuf_pkg::*;
#(
    parameter int ADDR_W = 14,
    localparam int WAW = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [WAW-1:0]    word,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] dlane
);
    assign word = addr[ADDR_W-1:2];

    // Derive the lane mask and replicate the data into every lane it may occupy.
    always_comb begin
        case (acc_size_e'(size))
            ACC_BYTE: begin
                be    = 4'b0001 << addr[1:0];
                dlane = {4{din[7:0]}};
            end
            ACC_HALF: begin
                be    = addr[1] ? 4'b1100 : 4'b0011;
                dlane = {2{din[15:0]}};
            end
            default: begin
                be    = 4'b1111;
                dlane = din;
            end
        endcase
    end
endmodule

// File: rtl/sram_wbuf_array.sv
// Synchronous single-ported word array with per-byte write enables.
// Assumes that write and read are never requested in the same cycle.
// The contents are not reset.
module sram_wbuf_array
    import sram_wbuf_pkg::*;
#(
    parameter int WORDS = 4096,
    localparam int WAW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [WAW-1:0]    waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [WAW-1:0]    raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Byte-masked write of the committed entry.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (be[i]) mem[waddr][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    // Registered read of the requested word.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/sram_wbuf_post.sv
// One-entry posted-write buffer. Every accepted write pushes the previous
// entry out to the array and takes its place in the same cycle.
// Assumes that reset may drop the entry, which is the intended behaviour.
module sram_wbuf_post
    import sram_wbuf_pkg::*;
#(
    parameter int WAW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WAW-1:0]    wr_word,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pend_valid,
    output logic [WAW-1:0]    pend_word,
    output logic [LANES-1:0]  pend_be,
    output logic [DATA_W-1:0] pend_data,
    output logic              commit_en
);
    assign commit_en = wr_en && pend_valid;

    // Occupancy flag: cleared by reset, set by the first accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_valid <= 1'b0;
        else if (wr_en) pend_valid <= 1'b1;
    end

    // Entry payload: replaced on every accepted write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pend_word <= wr_word;
            pend_be   <= wr_be;
            pend_data <= wr_data;
        end
    end
endmodule

// File: rtl/sram_wbuf_ctrl.sv
// Top level of the SRAM controller with a posted write. It accepts one request
// per cycle, posts writes into a one-entry buffer, and answers reads one cycle
// later, laying the held write over the array data.
// Assumes that MEM_BYTES is a power of two and at least 16.
module sram_wbuf_ctrl
    import sram_wbuf_pkg::*;
#(
    parameter int MEM_BYTES = 16384,
    localparam int ADDR_W = $clog2(MEM_BYTES),
    localparam int WORDS  = MEM_BYTES / 4,
    localparam int WAW    = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [WAW-1:0]    acc_word;
    logic [LANES-1:0]  acc_be;
    logic [DATA_W-1:0] acc_data;
    logic              wr_go, rd_go;
    logic              pend_valid, commit_en;
    logic [WAW-1:0]    pend_word;
    logic [LANES-1:0]  pend_be;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] arr_q;
    logic              hit_q;
    logic [LANES-1:0]  hit_be_q;
    logic [DATA_W-1:0] hit_data_q;
    logic              ready_q, rsp_q;

    assign wr_go = req_valid && req_ready && req_write;
    assign rd_go = req_valid && req_ready && !req_write;

    sram_wbuf_lanes #(.ADDR_W(ADDR_W)) lanes_i (
        .addr(req_addr), .size(req_size), .din(req_wdata),
        .word(acc_word), .be(acc_be), .dlane(acc_data)
    );

    sram_wbuf_post #(.WAW(WAW)) post_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go),
        .wr_word(acc_word), .wr_be(acc_be), .wr_data(acc_data),
        .pend_valid(pend_valid), .pend_word(pend_word),
        .pend_be(pend_be), .pend_data(pend_data), .commit_en(commit_en)
    );

    sram_wbuf_array #(.WORDS(WORDS)) array_i (
        .clk(clk), .we(commit_en), .be(pend_be), .waddr(pend_word),
        .wdata(pend_data), .re(rd_go), .raddr(acc_word), .rdata(arr_q)
    );

    // Ready goes high one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end
    assign req_ready = ready_q;

    // Read response valid, one cycle after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= 1'b0;
        else        rsp_q <= rd_go;
    end
    assign rsp_valid = rsp_q;

    // Snapshot of the held write for a read that hits the same word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (rd_go) begin
            hit_q      <= pend_valid && (pend_word == acc_word);
            hit_be_q   <= pend_be;
            hit_data_q <= pend_data;
        end
    end

    // Per-lane merge of the held bytes over the array word.
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign rsp_rdata[8*g +: 8] = (hit_q && hit_be_q[g]) ? hit_data_q[8*g +: 8]
                                                            : arr_q[8*g +: 8];
    end
endmodule

// File: rtl/sram_wbuf_chk.sv
// Protocol and ordering checks for sram_wbuf_ctrl, attached with bind.
module sram_wbuf_chk
    import sram_wbuf_pkg::*;
#(
    parameter int ADDR_W = 14,
    localparam int WAW = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              commit_en,
    input logic [LANES-1:0]  pend_be,
    input logic [WAW-1:0]    pend_word,
    input logic              pend_valid
);
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid); // R5
    AST_RSP_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !(req_valid && !req_write)) |=> !rsp_valid); // R5
    AST_COMMIT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (req_valid && req_write)); // R3
    AST_COMMIT_PREV_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) ##1 (req_valid && req_write)
        |-> commit_en && (pend_word == $past(req_addr[ADDR_W-1:2]))); // R9
    AST_COMMIT_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> ($countones(pend_be) == 1 || pend_be == 4'b0011 ||
                       pend_be == 4'b1100 || pend_be == 4'b1111)); // R2
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !pend_valid && !rsp_valid); // R6
endmodule

bind sram_wbuf_ctrl sram_wbuf_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .commit_en(commit_en), .pend_be(pend_be), .pend_word(pend_word),
    .pend_valid(pend_valid)
);

// File: tb/sram_wbuf_ctrl_tb_top.sv
// Near-exhaustive bench on a 64-byte configuration. A byte-level reference
// model is computed in the bench from the requirements.
module sram_wbuf_ctrl_tb_top;
    localparam int MB = 64;
    localparam int AW = $clog2(MB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [31:0]   rsp_rdata;

    int checks = 0, fails = 0;

    logic [7:0] cm [MB];
    bit         pv;
    int         pw;
    logic [7:0] pd [4];
    bit         pm [4];

    always #4 clk = ~clk;

    sram_wbuf_ctrl #(.MEM_BYTES(MB)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference write: the held entry goes to the committed image, then the new one is held.
    task automatic m_write(input int a, input int sz, input logic [31:0] d);
        int n = 1 << (sz > 2 ? 2 : sz);
        int base = a & 3 & ~(n - 1);
        if (pv) for (int i = 0; i < 4; i++) if (pm[i]) cm[pw*4+i] = pd[i];
        pv = 1; pw = a / 4;
        for (int i = 0; i < 4; i++) begin
            pm[i] = (i >= base) && (i < base + n);
            pd[i] = pm[i] ? d[8*(i-base) +: 8] : 8'h00;
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] r;
        int w = a / 4;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = (pv && pw == w && pm[i]) ? pd[i] : cm[w*4+i];
        return r;
    endfunction

    task automatic wr(input int a, input int sz, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_size = 2'(sz); req_addr = AW'(a); req_wdata = d;
        m_write(a, sz, d);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd(input string req, input int a, input int sz);
        req_valid = 1; req_write = 0; req_size = 2'(sz); req_addr = AW'(a);
        @(negedge clk);
        req_valid = 0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check(req, rsp_rdata, m_read(a));
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R8 ready in reset", 32'(req_ready), 32'd0);
        check("R8 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        pv = 0;
        rst_n = 1;
        @(negedge clk);
        check("R8 ready after reset", 32'(req_ready), 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        pv = 0;
        @(negedge clk);
        do_reset();
        // Fill every word, then force the last fill out of the buffer.
        for (int w = 0; w < MB/4; w++) wr(w*4, 2, 32'h1000_0000 + 32'(w) * 32'h0101_0101);
        wr(MB-4, 2, 32'h1000_0000 + 32'(MB/4-1) * 32'h0101_0101);
        @(negedge clk);
        check("R5 no rsp when idle", 32'(rsp_valid), 32'd0);
        // R1 R2 R4 R5: every address with every size, read back at two sizes.
        for (int a = 0; a < MB; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                wr(a, sz, 32'hC3A5_0000 ^ (32'(a) * 32'h0107_0B0D) ^ 32'(sz * 77));
                rd("R4 merged word read", a, 2);
                rd("R1 byte-size read returns aligned word", a ^ 1, 0);
            end
        end
        // R6: the held write is dropped by reset.
        wr(8, 2, 32'hDEAD_BEEF);
        do_reset();
        for (int w = 0; w < MB/4; w++) rd("R6 image after reset", w*4, 2);
        // R7: an identical pair survives reset.
        wr(20, 1, 32'h0000_ABCD);
        wr(20, 1, 32'h0000_ABCD);
        do_reset();
        rd("R7 doubled write survives", 20, 1);
        // R3 R9: back-to-back writes to different words, partial lanes.
        wr(33, 0, 32'h0000_0055);
        wr(46, 1, 32'h0000_7788);
        wr(4, 2, 32'h0BAD_F00D);
        do_reset();
        rd("R9 byte commit lane 1", 33, 0);
        rd("R9 half commit upper lanes", 46, 1);
        rd("R3 last write not committed", 4, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule